// File: doc/BRIEF.md
# Block-Transfer SPI Master with Word FIFO

The block is an SPI master that moves a programmed number of bytes in one direction per transfer. Software writes the byte count into a length register, then starts the transfer through the control register. That write also chooses the serial clock rate, the target device, a 1-bit or 4-bit bus and the direction. Payload passes through a 32-bit-wide FIFO. In a write transfer software fills the FIFO and the engine drains it. In a read transfer the engine fills it and software drains it. Only one direction is ever active, so a single storage array serves both.

Bytes are packed little-endian: byte 0 of a word sits in bits 7:0. The final word of a transfer may be partial and then uses only its low bytes. Chip select goes active when a transfer starts and stays active after the transfer ends, until software releases it. This lets several transfers run inside one selection. When a transfer finishes, the block sets a sticky status flag that can raise the interrupt output and is cleared by writing 1.

The serial timing is SPI mode 0. SCLK idles low. The master drives data at the start of each beat and on each falling edge, and samples input on each rising edge. Register offsets are word indices on `regAddr`:

| Offset | Register | Fields |
|---|---|---|
| 0 | control | 2:0 clock select, 7:6 device, 12 bus width (1 = 4-bit), 13 direction (1 = write), 15 start / busy |
| 1 | select | 0 slave selected |
| 2 | length | 20:0 byte count |
| 3 | data | 31:0 FIFO word |
| 4 | status | 0 FIFO busy |
| 5 | interrupt mask | 0 finish masked when 1 |
| 6 | interrupt status | 0 finish flag, write 1 to clear |

Top module: `spi_blk_top`

## Requirements
- R1: After reset the outputs are idle and the control register is cleared. All `csN` lines are 1, `sclk` is 0, `sdOe` is 0 and `irq` is 0, and a read of offset 0 returns 0.
- R2: Each SCLK half period lasts 2^clkSel clock cycles, with clkSel in control bits 2:0. Within a byte, consecutive rising SCLK edges are 2^(clkSel+1) cycles apart.
- R3: A write with control bit 12 = 0 sends each byte MSB first on `sdOut[0]`, one bit per SCLK cycle, with `sdOe` = 4'b0001. Bytes are taken from FIFO words starting with bits 7:0, and the unused upper bytes of a final partial word are not sent.
- R4: A write with control bit 12 = 1 sends each byte as two nibbles on `sdOut[3:0]`, high nibble first, with `sdOe` = 4'hF.
- R5: A read with control bit 12 = 0 samples `sdIn[1]` on each rising SCLK edge, MSB first. Bytes are packed into FIFO words starting at bits 7:0, and the unused upper bytes of a final partial word are 0.
- R6: A read with control bit 12 = 1 samples `sdIn[3:0]` on each rising SCLK edge, high nibble first, with `sdOe` = 0, and packs bytes as in R5.
- R7: Control bit 15 reads 1 while a transfer runs. A control write during a transfer is ignored: the device field and the clock field keep their values.
- R8: Starting a transfer drives `csN[device]` low and sets select bit 0, with the device taken from control bits 7:6. The line stays low after the transfer ends, and a write of 0 to offset 1 while idle sets all `csN` lines to 1. At most one `csN` line is low at any time.
- R9: The length register stores bits 20:0, and bits 31:21 read as 0.
- R10: Status bit 0 means the FIFO is busy. In a write transfer it is 1 when 8 words are queued, and a data write then is ignored. In a read transfer it is 1 while no word is available, which includes the start of the transfer.
- R11: Interrupt status bit 0 becomes 1 when a transfer finishes, and a write with bit 0 = 1 clears it. `irq` is 1 exactly when that bit is 1 and mask bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops the FIFO on a data read) |
| regAddr | input | 3 | Register word offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from `regAddr` |
| sclk | output | 1 | Serial clock |
| csN | output | 4 | Active-low chip selects, one per device |
| sdOut | output | 4 | Serial data out |
| sdOe | output | 4 | Output enables for the data lines |
| sdIn | input | 4 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the following:
- At most one chip select is active.
- The selected device's line is low throughout a busy transfer, and the slave is still selected when busy falls.
- SCLK stays low and the data lines are not driven while idle.
- Output data holds still through the high phase of SCLK.
- A masked interrupt never appears on `irq`.

Only the bench's scenarios can show that the bit and nibble order, the little-endian packing and the partial-word handling are right. They also show the exact SCLK period for a chosen clock select, the FIFO-busy back-pressure in both directions, and the effect of a control write made during a transfer.

// File: rtl/spi_blk_pkg.sv
package spi_blk_pkg;

  // Register word offsets on regAddr
  localparam logic [2:0] OFF_CTRL   = 3'd0;
  localparam logic [2:0] OFF_SELECT = 3'd1;
  localparam logic [2:0] OFF_LENGTH = 3'd2;
  localparam logic [2:0] OFF_DATA   = 3'd3;
  localparam logic [2:0] OFF_STATUS = 3'd4;
  localparam logic [2:0] OFF_IMASK  = 3'd5;
  localparam logic [2:0] OFF_ISTAT  = 3'd6;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic flush;     // transfer accepted: empty FIFO, reset packing
    logic load;      // load next byte into the transmit shifter
    logic sample;    // rising SCLK: capture input
    logic shift;     // falling SCLK inside a byte: advance output
    logic byteDone;  // final falling SCLK of a byte
    logic lastByte;  // current byte is the final one of the transfer
  } engStrobe_t;

endpackage

// File: rtl/spi_blk_ctrl.sv
module spi_blk_ctrl
  import spi_blk_pkg::*;
#(
  parameter int LEN_W     = 21,
  parameter int CLK_SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic [LEN_W-1:0]     lenVal,
  input  logic [CLK_SEL_W-1:0] clkSel,
  input  logic                 quad,
  input  logic                 byteReady,
  output engStrobe_t           st,
  output logic                 busy,
  output logic                 finish,
  output logic                 sclk
);
  localparam int DIV_W = 1 << CLK_SEL_W;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_LOW, S_HIGH} state_t;

  state_t            state;
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  halfM1;
  logic [2:0]        beatCnt;
  logic [2:0]        lastBeat;
  logic [LEN_W-1:0]  bytesLeft;
  logic              tick;
  logic              endBeat;
  logic              sclkQ;

  assign halfM1   = (DIV_W'(1) << clkSel) - DIV_W'(1);
  assign tick     = (divCnt == halfM1);
  assign lastBeat = quad ? 3'd1 : 3'd7;
  assign endBeat  = (state == S_HIGH) && tick;

  always_comb begin
    st.flush    = (state == S_IDLE) && startReq;
    st.load     = (state == S_LOAD) && byteReady;
    st.sample   = (state == S_LOW) && tick;
    st.byteDone = endBeat && (beatCnt == lastBeat);
    st.shift    = endBeat && (beatCnt != lastBeat);
    st.lastByte = (bytesLeft == LEN_W'(1));
  end

  assign busy   = (state != S_IDLE);
  assign finish = (st.byteDone && st.lastByte) ||
                  (st.flush && (lenVal == '0));
  assign sclk   = sclkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      divCnt    <= '0;
      beatCnt   <= '0;
      bytesLeft <= '0;
      sclkQ     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (startReq && lenVal != '0) begin
          bytesLeft <= lenVal;
          state     <= S_LOAD;
        end
        S_LOAD: if (byteReady) begin
          divCnt  <= '0;
          beatCnt <= '0;
          state   <= S_LOW;
        end
        S_LOW: if (tick) begin
          divCnt <= '0;
          sclkQ  <= 1'b1;
          state  <= S_HIGH;
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
        S_HIGH: if (tick) begin
          divCnt <= '0;
          sclkQ  <= 1'b0;
          if (beatCnt == lastBeat) begin
            bytesLeft <= bytesLeft - LEN_W'(1);
            state     <= (bytesLeft == LEN_W'(1)) ? S_IDLE : S_LOAD;
          end else begin
            beatCnt <= beatCnt + 3'd1;
            state   <= S_LOW;
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_blk_dp.sv
module spi_blk_dp
  import spi_blk_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  engStrobe_t  st,
  input  logic        busy,
  input  logic        dirWrite,
  input  logic        quad,
  input  logic        busWrReq,
  input  logic        busRdReq,
  input  logic [31:0] busWrData,
  input  logic [3:0]  sdIn,
  output logic [31:0] fifoHead,
  output logic        fifoEmpty,
  output logic        fifoFull,
  output logic        byteReady,
  output logic [3:0]  sdOut
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [31:0]      mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [PTR_W:0]   count;
  logic [7:0]       txSr, rxSr;
  logic [31:0]      rxWord, rxMerged, pushData;
  logic [1:0]       byteIdx;
  logic             wordEnd, busPush, rxPush, engPop, busPop, push, pop;

  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count == (PTR_W+1)'(DEPTH));
  assign fifoHead  = mem[rdPtr];
  assign byteReady = dirWrite ? !fifoEmpty : !fifoFull;

  assign wordEnd  = (byteIdx == 2'd3) || st.lastByte;
  assign busPush  = busWrReq && busy && dirWrite && !fifoFull;
  assign busPop   = busRdReq && !dirWrite && !fifoEmpty;
  assign engPop   = st.byteDone && dirWrite && wordEnd;
  assign rxPush   = st.byteDone && !dirWrite && wordEnd;
  assign push     = busPush || rxPush;
  assign pop      = busPop || engPop;
  assign rxMerged = rxWord | (32'(rxSr) << {byteIdx, 3'b000});
  assign pushData = dirWrite ? busWrData : rxMerged;
  assign sdOut    = quad ? txSr[7:4] : {3'b000, txSr[7]};

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      txSr    <= '0;
      rxSr    <= '0;
      rxWord  <= '0;
      byteIdx <= '0;
    end else if (st.flush) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      txSr    <= '0;
      rxWord  <= '0;
      byteIdx <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_W'(DEPTH-1)) ? '0 : wrPtr + PTR_W'(1);
      if (pop)  rdPtr <= (rdPtr == PTR_W'(DEPTH-1)) ? '0 : rdPtr + PTR_W'(1);
      count <= count + (PTR_W+1)'(push) - (PTR_W+1)'(pop);

      if (st.load)
        txSr <= dirWrite ? fifoHead[{byteIdx, 3'b000} +: 8] : 8'h00;
      else if (st.shift)
        txSr <= quad ? {txSr[3:0], 4'h0} : {txSr[6:0], 1'b0};

      if (st.sample)
        rxSr <= quad ? {rxSr[3:0], sdIn} : {rxSr[6:0], sdIn[1]};

      if (st.byteDone) begin
        byteIdx <= byteIdx + 2'd1;
        rxWord  <= rxPush ? 32'h0 : rxMerged;
      end
    end
  end
endmodule

// File: rtl/spi_blk_top.sv
module spi_blk_top
  import spi_blk_pkg::*;
#(
  parameter int LEN_W      = 21,
  parameter int CLK_SEL_W  = 3,
  parameter int DEV_W      = 2,
  parameter int FIFO_DEPTH = 8,
  localparam int NUM_DEV   = 1 << DEV_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [2:0]         regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic               sclk,
  output logic [NUM_DEV-1:0] csN,
  output logic [3:0]         sdOut,
  output logic [3:0]         sdOe,
  input  logic [3:0]         sdIn,
  output logic               irq
);
  logic [CLK_SEL_W-1:0] clkSelQ;
  logic [DEV_W-1:0]     devQ;
  logic                 quadQ, dirQ, selectedQ, maskQ, istatQ;
  logic [LEN_W-1:0]     lenQ;
  logic                 busy, finish, startReq, ctrlWr;
  logic                 fifoEmpty, fifoFull, byteReady;
  logic [31:0]          fifoHead;
  engStrobe_t           st;

  assign ctrlWr   = regWrEn && (regAddr == OFF_CTRL) && !busy;
  assign startReq = ctrlWr && regWrData[15];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSelQ   <= '0;
      devQ      <= '0;
      quadQ     <= 1'b0;
      dirQ      <= 1'b0;
      lenQ      <= '0;
      selectedQ <= 1'b0;
      maskQ     <= 1'b0;
      istatQ    <= 1'b0;
    end else begin
      if (ctrlWr) begin
        clkSelQ <= regWrData[CLK_SEL_W-1:0];
        devQ    <= regWrData[6 +: DEV_W];
        quadQ   <= regWrData[12];
        dirQ    <= regWrData[13];
      end
      if (regWrEn && regAddr == OFF_LENGTH) lenQ  <= regWrData[LEN_W-1:0];
      if (regWrEn && regAddr == OFF_IMASK)  maskQ <= regWrData[0];
      if (st.flush)
        selectedQ <= 1'b1;
      else if (regWrEn && regAddr == OFF_SELECT && !regWrData[0] && !busy)
        selectedQ <= 1'b0;
      if (finish)
        istatQ <= 1'b1;
      else if (regWrEn && regAddr == OFF_ISTAT && regWrData[0])
        istatQ <= 1'b0;
    end
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_cs
    assign csN[d] = !(selectedQ && (devQ == DEV_W'(d)));
  end

  assign sdOe = !busy ? 4'h0 : (quadQ ? (dirQ ? 4'hF : 4'h0) : 4'b0001);
  assign irq  = istatQ && !maskQ;

  always_comb begin
    regRdData = 32'h0;
    case (regAddr)
      OFF_CTRL: begin
        regRdData[CLK_SEL_W-1:0] = clkSelQ;
        regRdData[6 +: DEV_W]    = devQ;
        regRdData[12]            = quadQ;
        regRdData[13]            = dirQ;
        regRdData[15]            = busy;
      end
      OFF_SELECT: regRdData[0] = selectedQ;
      OFF_LENGTH: regRdData    = 32'(lenQ);
      OFF_DATA:   regRdData    = fifoEmpty ? 32'h0 : fifoHead;
      OFF_STATUS: regRdData[0] = dirQ ? fifoFull : fifoEmpty;
      OFF_IMASK:  regRdData[0] = maskQ;
      OFF_ISTAT:  regRdData[0] = istatQ;
      default:    regRdData    = 32'h0;
    endcase
  end

  spi_blk_ctrl #(.LEN_W(LEN_W), .CLK_SEL_W(CLK_SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .lenVal(lenQ),
    .clkSel(clkSelQ), .quad(quadQ), .byteReady(byteReady),
    .st(st), .busy(busy), .finish(finish), .sclk(sclk)
  );

  spi_blk_dp #(.DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .busy(busy), .dirWrite(dirQ),
    .quad(quadQ), .busWrReq(regWrEn && regAddr == OFF_DATA),
    .busRdReq(regRdEn && regAddr == OFF_DATA), .busWrData(regWrData),
    .sdIn(sdIn), .fifoHead(fifoHead), .fifoEmpty(fifoEmpty),
    .fifoFull(fifoFull), .byteReady(byteReady), .sdOut(sdOut)
  );
endmodule

// File: rtl/spi_blk_chk.sv
module spi_blk_chk #(
  parameter int DEV_W   = 2,
  parameter int NUM_DEV = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               busy,
  input logic               sclk,
  input logic [NUM_DEV-1:0] csN,
  input logic [3:0]         sdOut,
  input logic [3:0]         sdOe,
  input logic               irq,
  input logic               maskBit,
  input logic               selected,
  input logic [DEV_W-1:0]   devSel
);
  p_cs_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  p_cs_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !csN[devSel]);

  p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> selected);

  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk);

  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(sdOut));

  p_oe_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sdOe == 4'h0));

  p_irq_mask_r11: assert property (@(posedge clk) disable iff (!rstN)
    maskBit |-> !irq);
endmodule

bind spi_blk_top spi_blk_chk #(.DEV_W(DEV_W), .NUM_DEV(NUM_DEV)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .sclk(sclk), .csN(csN),
  .sdOut(sdOut), .sdOe(sdOe), .irq(irq), .maskBit(maskQ),
  .selected(selectedQ), .devSel(devQ)
);

// File: tb/spi_blk_top_tb.sv
module spi_blk_top_tb;
  localparam logic [2:0] A_CTRL = 3'd0, A_SEL = 3'd1, A_LEN = 3'd2,
                         A_DATA = 3'd3, A_STAT = 3'd4, A_MASK = 3'd5,
                         A_ISTAT = 3'd6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, regWrEn, regRdEn, sclk, irq;
  logic [2:0]  regAddr;
  logic [31:0] regWrData, regRdData;
  logic [3:0]  csN, sdOut, sdOe, sdIn;

  spi_blk_top u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .sclk(sclk), .csN(csN), .sdOut(sdOut), .sdOe(sdOe), .sdIn(sdIn),
    .irq(irq)
  );

  int    nChecks = 0, nFails = 0;
  bit    done = 0;
  string curTag = "R3";

  logic [7:0]  expTx[$];
  logic [31:0] expRx[$];
  bit          monWrite = 0, monQuad = 0;
  int          beat = 0, riseCnt = 0, slvIdx = 0;
  logic [7:0]  acc = 8'h0;
  logic [7:0]  slvBytes [16];
  realtime     riseT0, riseT1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  // Monitor: captures written bytes on rising SCLK, advances slave stream
  always @(posedge sclk) begin
    if (riseCnt == 0) riseT0 = $realtime;
    if (riseCnt == 1) riseT1 = $realtime;
    riseCnt++;
    slvIdx++;
    if (monWrite) begin
      acc = monQuad ? {acc[3:0], sdOut} : {acc[6:0], sdOut[0]};
      beat++;
      if (beat == (monQuad ? 2 : 8)) begin
        beat = 0;
        check(curTag, {28'h0, sdOe}, monQuad ? 32'hF : 32'h1);
        if (expTx.size() == 0) check(curTag, {24'h0, acc}, 32'hFFFF_FFFF);
        else check(curTag, {24'h0, acc}, {24'h0, expTx.pop_front()});
      end
    end
  end

  // Slave data model driving sdIn
  always_comb begin
    logic [7:0] b;
    if (monQuad) begin
      b = slvBytes[(slvIdx / 2) % 16];
      sdIn = (slvIdx % 2 == 0) ? b[7:4] : b[3:0];
    end else begin
      b = slvBytes[(slvIdx / 8) % 16];
      sdIn = {2'b00, b[7 - (slvIdx % 8)], 1'b0};
    end
  end

  task automatic busWrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #2 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    v = 32'h8000;
    while (v[15]) busRead(A_CTRL, v);
  endtask

  function automatic logic [7:0] genByte(int seed, int k);
    return 8'(seed + k * 37);
  endfunction

  function automatic logic [31:0] ctrlWord(bit dir, bit quad, int dev, int cs);
    return (32'h1 << 15) | (32'(dir) << 13) | (32'(quad) << 12) |
           (32'(dev) << 6) | 32'(cs);
  endfunction

  // Driver for write transfers: queues expected bytes, fills the FIFO
  task automatic runWrite(bit quad, int cs, int dev, int n, int seed,
                          bit fullTest);
    logic [31:0] v, w;
    int nWords;
    nWords = (n + 3) / 4;
    curTag = quad ? "R4" : "R3";
    for (int k = 0; k < n; k++) expTx.push_back(genByte(seed, k));
    monQuad = quad; monWrite = 1; beat = 0; riseCnt = 0;
    busWrite(A_LEN, 32'(n));
    busWrite(A_CTRL, ctrlWord(1'b1, quad, dev, cs));
    check("R8", {28'h0, csN}, {28'h0, ~(4'b1 << dev)});
    for (int i = 0; i < nWords; i++) begin
      w = 32'hEEEE_EEEE;  // unused bytes of a partial word carry junk
      for (int j = 0; j < 4; j++)
        if (i * 4 + j < n) w[j*8 +: 8] = genByte(seed, i * 4 + j);
      if (fullTest && i == 8) begin
        busRead(A_STAT, v);
        check("R10", v, 32'h1);
        busWrite(A_DATA, 32'hDEAD_BEEF);  // ignored while full
      end
      if (!(fullTest && i < 8)) begin
        v = 32'h1;
        while (v[0]) busRead(A_STAT, v);
      end
      busWrite(A_DATA, w);
    end
    if (cs >= 2) begin
      busWrite(A_CTRL, ctrlWord(1'b0, !quad, dev ^ 1, cs - 1));
      busRead(A_CTRL, v);
      check("R7", v, ctrlWord(1'b1, quad, dev, cs));
    end
    waitIdle();
    check(curTag, 32'(expTx.size()), 32'h0);
    monWrite = 0;
    if (cs == 2 || cs == 0) begin
      check("R2", 32'(int'((riseT1 - riseT0) / 20.0)), 32'(2 << cs));
    end
  endtask

  // Driver for read transfers: loads the slave and queues expected words
  task automatic runRead(bit quad, int cs, int dev, int n, int seed);
    logic [31:0] v, w;
    string tag;
    tag = quad ? "R6" : "R5";
    for (int k = 0; k < 16; k++) slvBytes[k] = genByte(seed, k);
    for (int i = 0; i < (n + 3) / 4; i++) begin
      w = 32'h0;
      for (int j = 0; j < 4; j++)
        if (i * 4 + j < n) w[j*8 +: 8] = genByte(seed, i * 4 + j);
      expRx.push_back(w);
    end
    monQuad = quad; slvIdx = 0; riseCnt = 0;
    busWrite(A_LEN, 32'(n));
    busWrite(A_CTRL, ctrlWord(1'b0, quad, dev, cs));
    busRead(A_STAT, v);
    check("R10", v, 32'h1);
    check(tag, {28'h0, sdOe}, quad ? 32'h0 : 32'h1);
    while (expRx.size() > 0) begin
      v = 32'h1;
      while (v[0]) busRead(A_STAT, v);
      busRead(A_DATA, v);
      check(tag, v, expRx.pop_front());
    end
    waitIdle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    rstN = 1'b0; regWrEn = 1'b0; regRdEn = 1'b0;
    regAddr = 3'd0; regWrData = 32'h0;
    for (int k = 0; k < 16; k++) slvBytes[k] = 8'h0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", {28'h0, csN}, 32'hF);
    check("R1", {31'h0, sclk}, 32'h0);
    check("R1", {28'h0, sdOe}, 32'h0);
    check("R1", {31'h0, irq}, 32'h0);
    busRead(A_CTRL, v);
    check("R1", v, 32'h0);

    // R9 length width
    busWrite(A_LEN, 32'hFFFF_FFFF);
    busRead(A_LEN, v);
    check("R9", v, 32'h001F_FFFF);

    // R3 / R2 / R7 / R8 / R11: 1-bit write, partial final word
    runWrite(1'b0, 2, 1, 6, 8'h5A, 1'b0);
    check("R8", {28'h0, csN}, 32'hD);
    busRead(A_SEL, v);
    check("R8", v, 32'h1);
    check("R11", {31'h0, irq}, 32'h1);
    busRead(A_ISTAT, v);
    check("R11", v, 32'h1);
    busWrite(A_ISTAT, 32'h1);
    @(negedge clk);
    check("R11", {31'h0, irq}, 32'h0);

    // R4 / R2: 4-bit write, fastest clock, device 2
    runWrite(1'b1, 0, 2, 5, 8'hC3, 1'b0);
    check("R8", {28'h0, csN}, 32'hB);
    busWrite(A_SEL, 32'h0);
    check("R8", {28'h0, csN}, 32'hF);
    busRead(A_SEL, v);
    check("R8", v, 32'h0);
    busWrite(A_ISTAT, 32'h1);

    // R5: 1-bit read, 7 bytes
    runRead(1'b0, 1, 0, 7, 8'h91);

    // R6 / R11: 4-bit read, masked interrupt
    busWrite(A_MASK, 32'h1);
    busWrite(A_ISTAT, 32'h1);
    runRead(1'b1, 3, 3, 4, 8'h17);
    check("R11", {31'h0, irq}, 32'h0);
    busRead(A_ISTAT, v);
    check("R11", v, 32'h1);
    busWrite(A_MASK, 32'h0);
    @(negedge clk);
    check("R11", {31'h0, irq}, 32'h1);
    busWrite(A_ISTAT, 32'h1);

    // R10: write FIFO full back-pressure, 9 words
    runWrite(1'b0, 4, 0, 36, 8'h3C, 1'b1);
    check("R8", {28'h0, csN}, 32'hE);

    summary();
  end
endmodule